// File: doc/BRIEF.md
# Pattern-Driven Serial Clock and Data Generator

This block produces a synchronous serial clock and a serial data line by replaying two stored bit patterns rather than by running a protocol state machine. The host writes a clock pattern word and a data pattern word into holding registers, then picks a pattern length, a divider period and an advance mode, and pulses a start strobe. The start strobe copies both holding words into two working pattern registers. From then on, a programmable divider issues one advance tick every few system clocks. On each tick both working registers move right by one position. Bit 0 of the clock register is the serial clock pin and bit 0 of the data register is the data pin.

Each serial data bit spans two pattern positions, with one clock edge between its neighbours. A 16-position pattern therefore carries one 8-bit word. A built-in pattern helper fills both holding registers from a data word and a chosen clock polarity and phase, which covers all four SPI modes. In rotate mode, the bit leaving position 0 re-enters at the top of the programmed length. After one full pass each pin is back at its first value, so the clock pin rests at its idle polarity. In shift mode, zeros fill from the top. The serial clock period is the divider period times the number of pattern positions per clock cycle.

Top module: `wavepat_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sclk_o`, `sdat_o` and `done_o` are 0 after that edge and both holding words are cleared.
- R2: With `adv_mode`=0 (rotate), after a start with clamped length L, step k (k ticks after start) drives bit (k mod L) of each loaded word onto its pin. Loaded bits at positions L and above are treated as 0, so step L shows bit 0 again.
- R3: With `adv_mode`=1 (shift), step k drives bit k of each loaded word for k < L. Step L and everything after show 0 on both pins.
- R4: Ticks occur every P system clocks after the start edge, where P is `div_period`; a `div_period` of 0 behaves as 1.
- R5: A `pat_len` below 2 behaves as 2 and one above the pattern width (32) behaves as 32.
- R6: `done_o` is high for exactly one cycle, in the cycle that follows the edge L·P clocks after the start edge, and all advancing stops there.
- R7: A write through `ld_spi_we` builds the clock pattern with bit j = `spi_cpol` XOR (j odd) for j < 16. It builds the data pattern with positions 2k and 2k+1 both equal to `spi_word` bit (7-k), so the most significant bit goes first. When `spi_cpha`=1 the data pattern is rotated up by one position: position 0 holds `spi_word` bit 0 and bit (7-k) sits at positions 2k+1 and 2k+2. Positions 16 and above are 0.
- R8: Both pins change only at tick edges and the start edge, and they change on the same edge.
- R9: `ld_clk_we` and `ld_dat_we` store `ld_word` into the clock and data holding words. `ld_spi_we` takes priority over both. Holding-word writes and changes to length, period and mode made during a run do not affect that run; they apply at the next start.
- R10: A start during a run reloads both patterns, restarts the divider and step count, and the done pulse follows L·P clocks after the new start.
- R11: While idle, both pins keep the last value driven and no advance takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_clk_we | input | 1 | Write `ld_word` into the clock holding word |
| ld_dat_we | input | 1 | Write `ld_word` into the data holding word |
| ld_word | input | 32 | Host pattern word |
| ld_spi_we | input | 1 | Fill both holding words from the pattern helper |
| spi_cpol | input | 1 | Helper clock idle level |
| spi_cpha | input | 1 | Helper phase select (data leads by one position when 1) |
| spi_word | input | 8 | Helper data word, sent most significant bit first |
| div_period | input | 16 | System clocks per tick (0 acts as 1) |
| pat_len | input | 6 | Pattern length in positions (clamped to 2..32) |
| adv_mode | input | 1 | 0 rotate once, 1 shift once |
| start | input | 1 | Load patterns and begin a pass |
| sclk_o | output | 1 | Serial clock pin |
| sdat_o | output | 1 | Serial data pin |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The hardest conditions to reach are those where a new start or host writes land part-way through a pass. Reaching them means placing stimulus at a known tick count relative to an earlier start, and then telling the replay of old values apart from new ones. The bench drives every input on the falling edge and counts falling edges from the start strobe. This lets it re-strobe after exactly three ticks, or rewrite the clock word, length, period and mode one cycle after a start. It then confirms that the old pass runs to completion and that the next pass picks up the new settings. The pattern table covers the clamp boundaries and a zero divider period, and the helper is run in all four polarity and phase combinations, one of them written while a conflicting raw write is also asserted.

// File: rtl/wpg_pkg.sv
// Shared types for the pattern-driven serial generator.
package wpg_pkg;
    // Advance rule applied to the working pattern registers on each tick.
    typedef enum logic {
        MODE_ROTATE = 1'b0,
        MODE_SHIFT  = 1'b1
    } adv_mode_e;
endpackage

// File: rtl/wpg_tick_div.sv
// Divider that emits one advance tick every PERIOD system clocks.
// Assumes period is non-zero and stays constant while run is high.
// A restart clears the count so the first tick lands PERIOD clocks later.
module wpg_tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == period - DIV_W'(1));
    assign tick   = run && !restart && at_end;

    // Count system clocks within one tick interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_end ? '0 : cnt_q + DIV_W'(1);
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > DIV_W'(1)) |=> !tick); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |-> (cnt_q < period)); // R4
endmodule

// File: rtl/wpg_spi_pattern.sv
// Pattern helper: builds clock and data pattern words for one serial word.
// Each data bit occupies two positions, most significant bit first.
// The clock pattern alternates per position and is inverted for polarity 1.
// Phase 1 rotates the data pattern up one position so the clock idle level stays at position 0.
// Assumes 2*WORD_W <= PAT_W.
module wpg_spi_pattern #(
    parameter int WORD_W = 8,
    parameter int PAT_W  = 32
) (
    input  logic              cpol,
    input  logic              cpha,
    input  logic [WORD_W-1:0] word,
    output logic [PAT_W-1:0]  clk_pat,
    output logic [PAT_W-1:0]  dat_pat
);
    localparam int HP_W = 2 * WORD_W;

    logic [HP_W-1:0] clk_lo;
    logic [HP_W-1:0] dup;
    logic [HP_W-1:0] dat_lo;

    for (genvar j = 0; j < HP_W; j++) begin : g_pos
        assign clk_lo[j] = cpol ^ ((j % 2) == 1);
        assign dup[j]    = word[WORD_W-1-(j/2)];
    end

    assign dat_lo = cpha ? {dup[HP_W-2:0], dup[HP_W-1]} : dup;

    if (HP_W < PAT_W) begin : g_pad
        assign clk_pat = {{(PAT_W-HP_W){1'b0}}, clk_lo};
        assign dat_pat = {{(PAT_W-HP_W){1'b0}}, dat_lo};
    end else begin : g_full
        assign clk_pat = clk_lo;
        assign dat_pat = dat_lo;
    end

    // Check that the clock pattern carries one high position per data bit.
    always_comb begin
        AST_HELPER_BALANCE: assert ($countones(clk_pat) == WORD_W); // R7
    end
endmodule

// File: rtl/wpg_pat_lane.sv
// One working pattern register. Bit 0 is the lane's pin value.
// On load it takes load_val masked to the length. On adv it moves right by one:
// rotate puts bit 0 into position len-1, shift fills with zero.
// Assumes 2 <= len <= PAT_W and that len and mode are steady during a pass.
module wpg_pat_lane
    import wpg_pkg::*;
#(
    parameter int PAT_W = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PAT_W-1:0] load_val,
    input  logic [LEN_W-1:0] len,
    input  adv_mode_e        mode,
    input  logic             adv,
    output logic             out_bit
);
    logic [PAT_W-1:0] pat_q;
    logic [PAT_W-1:0] nxt;
    logic [PAT_W-1:0] in_len;
    logic [PAT_W-1:0] masked;

    for (genvar j = 0; j < PAT_W; j++) begin : g_bit
        logic up_bit;
        logic top_pos;
        if (j == PAT_W - 1) begin : g_top
            assign up_bit = 1'b0;
        end else begin : g_mid
            assign up_bit = pat_q[j+1];
        end
        assign in_len[j] = (LEN_W'(j) < len);
        assign top_pos   = (LEN_W'(j + 1) == len);
        assign masked[j] = load_val[j] & in_len[j];
        assign nxt[j]    = top_pos ? ((mode == MODE_ROTATE) ? pat_q[0] : 1'b0)
                                   : (in_len[j] ? up_bit : 1'b0);
    end

    // Hold, load or advance the working pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (load) begin
            pat_q <= masked;
        end else if (adv) begin
            pat_q <= nxt;
        end
    end

    assign out_bit = pat_q[0];

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(pat_q)); // R11
endmodule

// File: rtl/wavepat_gen.sv
// Top of the pattern-driven serial generator.
// Holds the host pattern words, latches length, period and mode at start,
// sequences one pass of L ticks and drives the serial clock and data pins
// from bit 0 of two working pattern lanes. Assumes 2*WORD_W <= PAT_W.
module wavepat_gen
    import wpg_pkg::*;
#(
    parameter int PAT_W  = 32,
    parameter int DIV_W  = 16,
    parameter int WORD_W = 8,
    localparam int LEN_W = $clog2(PAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_clk_we,
    input  logic              ld_dat_we,
    input  logic [PAT_W-1:0]  ld_word,
    input  logic              ld_spi_we,
    input  logic              spi_cpol,
    input  logic              spi_cpha,
    input  logic [WORD_W-1:0] spi_word,
    input  logic [DIV_W-1:0]  div_period,
    input  logic [LEN_W-1:0]  pat_len,
    input  logic              adv_mode,
    input  logic              start,
    output logic              sclk_o,
    output logic              sdat_o,
    output logic              done_o
);
    localparam int N_LANE = 2;

    logic [PAT_W-1:0] clk_hold_q, dat_hold_q;
    logic [PAT_W-1:0] helper_clk, helper_dat;
    logic [LEN_W-1:0] len_in_c, len_q, len_use;
    logic [DIV_W-1:0] per_in_c, per_q;
    adv_mode_e        mode_in, mode_q, mode_use;
    logic             busy_q, done_q, tick;
    logic [LEN_W-1:0] step_q;
    logic [PAT_W-1:0] lane_src [N_LANE];
    logic [N_LANE-1:0] lane_bit;

    wpg_spi_pattern #(.WORD_W(WORD_W), .PAT_W(PAT_W)) u_helper (
        .cpol    (spi_cpol),
        .cpha    (spi_cpha),
        .word    (spi_word),
        .clk_pat (helper_clk),
        .dat_pat (helper_dat)
    );

    // Clamp the requested length and period to their legal ranges.
    always_comb begin
        len_in_c = pat_len;
        if (pat_len < LEN_W'(2)) begin
            len_in_c = LEN_W'(2);
        end else if (pat_len > LEN_W'(PAT_W)) begin
            len_in_c = LEN_W'(PAT_W);
        end
        per_in_c = (div_period == '0) ? DIV_W'(1) : div_period;
        mode_in  = adv_mode ? MODE_SHIFT : MODE_ROTATE;
    end

    // Host holding words; the helper write wins over raw writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_hold_q <= '0;
            dat_hold_q <= '0;
        end else if (ld_spi_we) begin
            clk_hold_q <= helper_clk;
            dat_hold_q <= helper_dat;
        end else begin
            if (ld_clk_we) clk_hold_q <= ld_word;
            if (ld_dat_we) dat_hold_q <= ld_word;
        end
    end

    // Latch pass settings at start so mid-pass edits wait for the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= LEN_W'(2);
            per_q  <= DIV_W'(1);
            mode_q <= MODE_ROTATE;
        end else if (start) begin
            len_q  <= len_in_c;
            per_q  <= per_in_c;
            mode_q <= mode_in;
        end
    end

    // Pass sequencer: counts ticks and pulses done after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                step_q <= '0;
            end else if (tick) begin
                if (step_q == len_q - LEN_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + LEN_W'(1);
                end
            end
        end
    end

    wpg_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (busy_q),
        .period  (per_q),
        .tick    (tick)
    );

    assign len_use  = start ? len_in_c : len_q;
    assign mode_use = start ? mode_in  : mode_q;
    assign lane_src[0] = clk_hold_q;
    assign lane_src[1] = dat_hold_q;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        wpg_pat_lane #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start),
            .load_val (lane_src[g]),
            .len      (len_use),
            .mode     (mode_use),
            .adv      (tick),
            .out_bit  (lane_bit[g])
        );
    end

    assign sclk_o = lane_bit[0];
    assign sdat_o = lane_bit[1];
    assign done_o = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q); // R6
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy_q && step_q == '0)); // R10
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (step_q < len_q)); // R5
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (len_q >= LEN_W'(2) && len_q <= LEN_W'(PAT_W))); // R5
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !tick); // R11
    AST_PINS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> ($stable(sclk_o) && $stable(sdat_o))); // R8
endmodule

// File: tb/wavepat_gen_test.sv
module wavepat_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_clk_we = 1'b0, ld_dat_we = 1'b0, ld_spi_we = 1'b0;
    logic [31:0] ld_word = '0;
    logic        spi_cpol = 1'b0, spi_cpha = 1'b0;
    logic [7:0]  spi_word = '0;
    logic [15:0] div_period = 16'd1;
    logic [5:0]  pat_len = 6'd16;
    logic        adv_mode = 1'b0;
    logic        start = 1'b0;
    logic        sclk_o, sdat_o, done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wavepat_gen uut (
        .clk(clk), .rst_n(rst_n), .ld_clk_we(ld_clk_we), .ld_dat_we(ld_dat_we),
        .ld_word(ld_word), .ld_spi_we(ld_spi_we), .spi_cpol(spi_cpol),
        .spi_cpha(spi_cpha), .spi_word(spi_word), .div_period(div_period),
        .pat_len(pat_len), .adv_mode(adv_mode), .start(start),
        .sclk_o(sclk_o), .sdat_o(sdat_o), .done_o(done_o)
    );

    typedef struct packed {
        logic        shm;
        logic [15:0] per;
        logic [5:0]  len;
        logic [31:0] cw;
        logic [31:0] dw;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd3, 6'd16, 32'h0000_AAAA, 32'h0000_F00F},  // R2
        '{1'b1, 16'd2, 6'd16, 32'h0000_5555, 32'h0000_00FF},  // R3
        '{1'b0, 16'd1, 6'd8,  32'hFFFF_FF35, 32'h0000_00C3},  // R2 masking
        '{1'b1, 16'd5, 6'd32, 32'h8000_0001, 32'hDEAD_BEEF},  // R3 full width
        '{1'b0, 16'd0, 6'd5,  32'h0000_001B, 32'h0000_000A},  // R4 period 0
        '{1'b0, 16'd2, 6'd1,  32'h0000_0002, 32'h0000_0001},  // R5 low clamp
        '{1'b1, 16'd1, 6'd45, 32'h0F0F_3C3C, 32'hA5A5_0001}   // R5 high clamp
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clamp_len(int l);
        if (l < 2) return 2;
        if (l > 32) return 32;
        return l;
    endfunction

    function automatic int clamp_per(int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic logic exp_bit(logic [31:0] w, int l, logic shm, int k);
        logic [31:0] m;
        m = (l >= 32) ? w : (w & ((32'd1 << l) - 32'd1));
        if (shm) return (k < l) ? m[k] : 1'b0;
        return m[k % l];
    endfunction

    task automatic write_words(logic [31:0] cw, logic [31:0] dw);
        @(negedge clk);
        ld_word = cw; ld_clk_we = 1'b1;
        @(negedge clk);
        ld_clk_we = 1'b0; ld_word = dw; ld_dat_we = 1'b1;
        @(negedge clk);
        ld_dat_we = 1'b0;
    endtask

    task automatic pulse_start(logic shm, logic [15:0] per, logic [5:0] len);
        @(negedge clk);
        adv_mode = shm; div_period = per; pat_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run one pass and check every step; tag names the mode requirement.
    task automatic run_pass(string tag, logic shm, logic [15:0] per, logic [5:0] len,
                            logic [31:0] cw, logic [31:0] dw);
        int lc, pc;
        logic ps, pd;
        lc = clamp_len(int'(len));
        pc = clamp_per(int'(per));
        pulse_start(shm, per, len);
        for (int k = 0; k <= lc; k++) begin
            if (k > 0) begin
                for (int w = 1; w <= pc; w++) begin
                    @(negedge clk);
                    if (w == 1 && pc > 1) begin
                        chk("R8 sclk between ticks", {31'd0, sclk_o}, {31'd0, exp_bit(cw, lc, shm, k-1)});
                        chk("R8 sdat between ticks", {31'd0, sdat_o}, {31'd0, exp_bit(dw, lc, shm, k-1)});
                    end
                end
            end
            chk({tag, " sclk step"}, {31'd0, sclk_o}, {31'd0, exp_bit(cw, lc, shm, k)});
            chk({tag, " sdat step"}, {31'd0, sdat_o}, {31'd0, exp_bit(dw, lc, shm, k)});
            if (k == lc || k == lc - 1)
                chk("R6 R4 R5 done timing", {31'd0, done_o}, {31'd0, (k == lc)});
        end
        ps = sclk_o; pd = sdat_o;
        repeat (10) @(negedge clk);
        chk("R6 done single cycle", {31'd0, done_o}, 32'd0);
        chk("R11 idle sclk hold", {31'd0, sclk_o}, {31'd0, ps});
        chk("R11 idle sdat hold", {31'd0, sdat_o}, {31'd0, pd});
    endtask

    // Helper load plus one rotate pass of 16 positions at period 2.
    task automatic run_spi(logic cpol, logic cpha, logic [7:0] w, logic raw_too);
        int j;
        logic ec, ed;
        @(negedge clk);
        spi_cpol = cpol; spi_cpha = cpha; spi_word = w; ld_spi_we = 1'b1;
        ld_word = 32'hFFFF_FFFF; ld_clk_we = raw_too; ld_dat_we = raw_too;
        @(negedge clk);
        ld_spi_we = 1'b0; ld_clk_we = 1'b0; ld_dat_we = 1'b0;
        pulse_start(1'b0, 16'd2, 6'd16);
        for (int k = 0; k <= 16; k++) begin
            if (k > 0) repeat (2) @(negedge clk);
            j = k % 16;
            ec = cpol ^ j[0];
            if (cpha) ed = (j == 0) ? w[0] : w[7 - ((j - 1) / 2)];
            else      ed = w[7 - (j / 2)];
            chk(raw_too ? "R9 helper priority sclk" : "R7 helper sclk", {31'd0, sclk_o}, {31'd0, ec});
            chk(raw_too ? "R9 helper priority sdat" : "R7 helper sdat", {31'd0, sdat_o}, {31'd0, ed});
        end
        chk("R7 clock rests at polarity", {31'd0, sclk_o}, {31'd0, cpol});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        bit seen_early;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 sclk reset", {31'd0, sclk_o}, 32'd0);
        chk("R1 sdat reset", {31'd0, sdat_o}, 32'd0);
        chk("R1 done reset", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;
        // R1: cleared holding words replay as zero
        run_pass("R1 cleared words", 1'b0, 16'd1, 6'd4, 32'd0, 32'd0);

        // Table of passes
        for (int v = 0; v < NV; v++) begin
            write_words(VECS[v].cw, VECS[v].dw);
            run_pass(VECS[v].shm ? "R3" : "R2", VECS[v].shm, VECS[v].per,
                     VECS[v].len, VECS[v].cw, VECS[v].dw);
        end

        // R7: all four polarity/phase combinations
        run_spi(1'b0, 1'b0, 8'hA5, 1'b0);
        run_spi(1'b0, 1'b1, 8'h3C, 1'b0);
        run_spi(1'b1, 1'b0, 8'hA5, 1'b0);
        run_spi(1'b1, 1'b1, 8'h96, 1'b0);
        // R9: helper write wins over simultaneous raw writes
        run_spi(1'b1, 1'b0, 8'h5A, 1'b1);

        // R10: restart after three ticks
        write_words(32'h0000_00F0, 32'h0000_0033);
        pulse_start(1'b0, 16'd2, 6'd8);
        repeat (6) @(negedge clk);
        pulse_start(1'b0, 16'd2, 6'd8);
        chk("R10 restart reloads sclk", {31'd0, sclk_o}, 32'd0);
        chk("R10 restart reloads sdat", {31'd0, sdat_o}, 32'd1);
        seen_early = 1'b0;
        for (int c = 1; c <= 16; c++) begin
            @(negedge clk);
            if (c < 16 && done_o) seen_early = 1'b1;
            if (c == 16) chk("R10 done after restart", {31'd0, done_o}, 32'd1);
        end
        chk("R10 no early done", {31'd0, seen_early}, 32'd0);

        // R9: edits during a pass wait for the next start
        write_words(32'h0000_000F, 32'h0000_0081);
        pulse_start(1'b0, 16'd1, 6'd8);
        for (int k = 0; k <= 8; k++) begin
            if (k > 0) @(negedge clk);
            chk("R9 sclk unaffected", {31'd0, sclk_o}, {31'd0, exp_bit(32'h0F, 8, 1'b0, k)});
            chk("R9 sdat unaffected", {31'd0, sdat_o}, {31'd0, exp_bit(32'h81, 8, 1'b0, k)});
            if (k == 0) begin
                ld_word = 32'hFFFF_FFFF; ld_clk_we = 1'b1;
                pat_len = 6'd3; div_period = 16'd4; adv_mode = 1'b1;
            end
            if (k == 1) ld_clk_we = 1'b0;
        end
        chk("R9 done on old length", {31'd0, done_o}, 32'd1);
        run_pass("R9 new settings", 1'b1, 16'd1, 6'd3, 32'hFFFF_FFFF, 32'h0000_0081);

        // R1: reset during a pass clears the pins
        write_words(32'h0000_FFFF, 32'h0000_FFFF);
        pulse_start(1'b0, 16'd3, 6'd16);
        chk("R1 pass running", {31'd0, sclk_o}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 sclk after reset", {31'd0, sclk_o}, 32'd0);
        chk("R1 sdat after reset", {31'd0, sdat_o}, 32'd0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R11 no advance after reset", {31'd0, sclk_o | done_o}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule